// File: doc/BRIEF.md
# Comparator change-detect interrupt unit

This block turns changes on two comparator outputs into interrupt requests. Both comparator results arrive as plain digital bits. They pass through a two-flop synchronizer and are then compared against a shadow copy. The shadow copy is refreshed only when software reads or writes the comparator status register. While the synchronized value and the shadow copy differ, the comparator's pending flag is set again on every clock. Clearing that flag therefore holds only after the status register has been accessed.

Software reaches the block through a simple register bus with a read strobe, a write strobe and an address. Software can write a 1 into a pending flag to raise a test interrupt. The interrupt line requires three enables to be on together: a per-comparator enable, a peripheral enable and a global enable. The pending flags are recorded whatever the enables are.

Top module: `cmp_chg_irq`

## Requirements
- R1: After reset every pending flag, source enable, peripheral enable, global enable and shadow bit is 0, `irq` is 0, and every register reads 0 while `cmp_in` is 0.
- R2: A read or a write of the status register (address 0) loads the shadow copy with the synchronized comparator values. A status read returns comparator 1 in bit 7 and comparator 0 in bit 6. Bits 5..0 read 0, and writes to this register change no readable state.
- R3: When a synchronized comparator value differs from its shadow bit and the status register is not accessed in that cycle, the comparator's flag is 1 after the next clock edge. The flag keeps being set on every edge while the difference lasts. The pending register (address 1) holds the flag of comparator 0 in bit 5 and that of comparator 1 in bit 6.
- R4: A write to the pending register loads bits 6..5 into the flags. Writing 1 forces a flag. Writing 0 clears it, except that a comparator still in mismatch sets its flag again in the same edge.
- R5: `irq` is 1 exactly when, for some comparator, both its flag and its source enable are 1, the peripheral enable is 1 and the global enable is 1. Source enables sit in bits 6..5 of the enable register (address 2) at the same positions as the flags. The control register (address 3) holds the peripheral enable in bit 6 and the global enable in bit 7.
- R6: Flags are set by a mismatch even while all enables are 0.
- R7: If the first cycle in which a synchronized value differs from its shadow bit is also a status-register access cycle, the reload wins. The change is absorbed and no flag is set for it.
- R8: A change on `cmp_in` shows in the status readback after two clock edges. It sets the flag on the third edge.
- R9: Reads of addresses 4 and above return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 2 | Comparator outputs; bit 0 is comparator 0 |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle `bus_rd` is high |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational from registered state, so it is due in the same cycle as the read strobe. Register writes, and the `irq` change they cause, are due one edge after the write strobe. A comparator input change reaches the status readback after two edges and the flag after three.

The bench drives inputs and strobes on falling edges. It samples outputs just after a falling edge, which places each sample after exactly the number of rising edges listed above. For the coincident-change case the bench times the status read to fall in the cycle right after the second synchronizer edge.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;

    // Number of comparators; the bit layout below is fixed for two.
    localparam int unsigned CMP_N = 2;
    localparam int unsigned DATA_W = 8;

    // Register offsets
    localparam int unsigned REG_STATUS = 0;
    localparam int unsigned REG_PEND   = 1;
    localparam int unsigned REG_ENABLE = 2;
    localparam int unsigned REG_CTRL   = 3;

    // Bit positions
    localparam int unsigned STAT_LSB = 6;   // comparator outputs at 7:6
    localparam int unsigned FLAG_LSB = 5;   // flags and enables at 6:5
    localparam int unsigned PE_BIT   = 6;
    localparam int unsigned GE_BIT   = 7;

    typedef logic [CMP_N-1:0] cmp_vec_t;

    typedef struct packed {
        cmp_vec_t flag;
        cmp_vec_t en;
        logic     pe;
        logic     ge;
    } regs_t;

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = async_i;
        for (int k = 1; k < int'(STAGES); k++) begin
            st_d.stg[k] = st_q.stg[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stg[STAGES-1];

endmodule

// File: rtl/cmp_mismatch.sv
module cmp_mismatch #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cmp_s_i,
    input  logic             reload_i,
    output logic [WIDTH-1:0] mismatch_o
);

    typedef struct packed {
        logic [WIDTH-1:0] shadow;
    } shd_st_t;

    shd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reload_i) begin
            st_d.shadow = cmp_s_i;
        end
        // A reload in this cycle absorbs any difference (R7)
        mismatch_o = (cmp_s_i ^ st_q.shadow) & {WIDTH{~reload_i}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: an access leaves the shadow equal to the value seen at that access
    p_shadow_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (st_q.shadow == $past(cmp_s_i)));

endmodule

// File: rtl/cmp_regfile.sv
module cmp_regfile
    import cmp_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  cmp_vec_t          cmp_s_i,
    input  cmp_vec_t          mismatch_i,
    output logic              status_acc_o,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);

    regs_t st_d, st_q;

    logic hit_stat, hit_pend, hit_en, hit_ctrl;
    logic unused_wdata;

    assign hit_stat = (bus_addr == ADDR_W'(REG_STATUS));
    assign hit_pend = (bus_addr == ADDR_W'(REG_PEND));
    assign hit_en   = (bus_addr == ADDR_W'(REG_ENABLE));
    assign hit_ctrl = (bus_addr == ADDR_W'(REG_CTRL));
    assign unused_wdata = ^bus_wdata[FLAG_LSB-1:0];

    assign status_acc_o = hit_stat & (bus_rd | bus_wr);

    always_comb begin
        st_d = st_q;
        if (bus_wr && hit_pend) begin
            st_d.flag = bus_wdata[FLAG_LSB +: CMP_N];
        end
        // A standing mismatch overrides a clear (R3, R4)
        st_d.flag = st_d.flag | mismatch_i;
        if (bus_wr && hit_en) begin
            st_d.en = bus_wdata[FLAG_LSB +: CMP_N];
        end
        if (bus_wr && hit_ctrl) begin
            st_d.pe = bus_wdata[PE_BIT];
            st_d.ge = bus_wdata[GE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_stat) begin
                bus_rdata[STAT_LSB +: CMP_N] = cmp_s_i;
            end else if (hit_pend) begin
                bus_rdata[FLAG_LSB +: CMP_N] = st_q.flag;
            end else if (hit_en) begin
                bus_rdata[FLAG_LSB +: CMP_N] = st_q.en;
            end else if (hit_ctrl) begin
                bus_rdata[PE_BIT] = st_q.pe;
                bus_rdata[GE_BIT] = st_q.ge;
            end
        end
    end

    assign irq_o = st_q.ge & st_q.pe & (|(st_q.flag & st_q.en));

    for (genvar i = 0; i < int'(CMP_N); i++) begin : g_chk
        // R3: a mismatch sets the flag on the next edge, whatever the enables
        p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
            mismatch_i[i] |=> st_q.flag[i]);
        // R4: a zero write with no mismatch clears the flag
        p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && hit_pend && !bus_wdata[FLAG_LSB+i] && !mismatch_i[i])
            |=> !st_q.flag[i]);
    end

    // R5: the request needs an enabled pending source
    p_irq_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|(st_q.flag & st_q.en)));

endmodule

// File: rtl/cmp_chg_irq.sv
module cmp_chg_irq
    import cmp_irq_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmp_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq
);

    cmp_vec_t cmp_s;
    cmp_vec_t mismatch;
    logic     status_acc;

    cmp_sync #(
        .WIDTH  (CMP_N),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_in),
        .sync_o  (cmp_s)
    );

    cmp_mismatch #(
        .WIDTH (CMP_N)
    ) u_mismatch (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_s_i    (cmp_s),
        .reload_i   (status_acc),
        .mismatch_o (mismatch)
    );

    cmp_regfile #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .cmp_s_i      (cmp_s),
        .mismatch_i   (mismatch),
        .status_acc_o (status_acc),
        .bus_rdata    (bus_rdata),
        .irq_o        (irq)
    );

endmodule

// File: tb/cmp_chg_irq_tb.sv
module cmp_chg_irq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmp_in = 2'b00;
    logic [3:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cmp_chg_irq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_in    (cmp_in),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // {enable reg, control reg, expected irq}; flag 0 is pending (R5)
    localparam logic [16:0] VEC [9] = '{
        {8'h00, 8'h00, 1'b0},
        {8'h20, 8'h00, 1'b0},
        {8'h00, 8'h40, 1'b0},
        {8'h20, 8'h40, 1'b0},
        {8'h00, 8'h80, 1'b0},
        {8'h20, 8'h80, 1'b0},
        {8'h00, 8'hC0, 1'b0},
        {8'h20, 8'hC0, 1'b1},
        {8'h40, 8'hC0, 1'b0}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_cmp(input logic [1:0] v);
        @(negedge clk);
        cmp_in = v;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        wait_cyc(3);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq", {7'b0, irq}, 8'h00);
        bus_read(4'd0, rd); check("R1 status", rd, 8'h00);
        bus_read(4'd1, rd); check("R1 pending", rd, 8'h00);
        bus_read(4'd2, rd); check("R1 enable", rd, 8'h00);
        bus_read(4'd3, rd); check("R1 control", rd, 8'h00);

        // R5: enable combinations over the vector table
        bus_write(4'd1, 8'h20);
        bus_read(4'd1, rd); check("R4 forced flag", rd, 8'h20);
        for (int i = 0; i < 9; i++) begin
            bus_write(4'd2, VEC[i][16:9]);
            bus_write(4'd3, VEC[i][8:1]);
            check($sformatf("R5 vec %0d irq", i), {7'b0, irq}, {7'b0, VEC[i][0]});
        end
        bus_read(4'd3, rd); check("R5 control readback", rd, 8'hC0);
        bus_write(4'd2, 8'h00);
        bus_write(4'd3, 8'h00);
        bus_write(4'd1, 8'h00);
        bus_read(4'd1, rd); check("R4 clear flag", rd, 8'h00);

        // R8: comparator 1 rises; flag not yet set before third edge
        set_cmp(2'b10);
        wait_cyc(1);
        bus_read(4'd1, rd); check("R8 flag before third edge", rd, 8'h00);
        bus_read(4'd1, rd); check("R3 R6 flag with enables off", rd, 8'h40);

        // R3: clear without status access does not hold
        bus_write(4'd1, 8'h00);
        bus_read(4'd1, rd); check("R3 clear during mismatch", rd, 8'h40);

        // R2: status read reloads shadow; then clear holds
        bus_read(4'd0, rd); check("R2 status readback", rd, 8'h80);
        bus_write(4'd1, 8'h00);
        wait_cyc(2);
        bus_read(4'd1, rd); check("R4 clear after reload", rd, 8'h00);

        // R2: a status write also reloads the shadow
        set_cmp(2'b11);
        wait_cyc(4);
        bus_write(4'd0, 8'hFF);
        bus_write(4'd1, 8'h00);
        bus_read(4'd1, rd); check("R2 write reloads shadow", rd, 8'h00);
        bus_read(4'd0, rd); check("R2 status write ignored", rd, 8'hC0);

        // R7: change coincident with status read is absorbed
        set_cmp(2'b10);
        wait_cyc(1);
        bus_read(4'd0, rd); check("R7 status shows new value", rd, 8'h80);
        wait_cyc(3);
        bus_read(4'd1, rd); check("R7 flag absorbed", rd, 8'h00);

        // R9: unmapped address
        bus_write(4'd2, 8'h60);
        bus_write(4'd5, 8'hFF);
        bus_read(4'd5, rd); check("R9 unmapped read", rd, 8'h00);
        bus_read(4'd2, rd); check("R9 enable unchanged", rd, 8'h60);
        bus_read(4'd3, rd); check("R9 control unchanged", rd, 8'h00);

        // R5: forced flag on comparator 1 with all enables raises irq
        bus_write(4'd1, 8'h40);
        bus_write(4'd3, 8'hC0);
        check("R5 comparator 1 irq", {7'b0, irq}, 8'h01);
        bus_write(4'd3, 8'h80);
        check("R5 peripheral enable off", {7'b0, irq}, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule